// File: doc/BRIEF.md
# Streaming CRC-32 Byte Engine

This block computes the standard 32-bit cyclic redundancy check over a stream of bytes at one byte per clock. Every accepted byte is folded into a 32-bit running remainder by one 256-entry lookup table, one XOR and one 8-bit shift. The table is computed while the design elaborates, so no memory image is loaded and no bit-serial shifter is used.

A block begins with a start pulse. Bytes arrive with a valid strobe, and the final byte carries a last flag. One cycle after the last byte the block raises a single-cycle done strobe. At the same moment it presents the codeword, which is the inverted remainder, and holds it until another block completes.

When the check-mode input is high at the start pulse, the block expects the stream to end with its own four CRC bytes, least significant first. The good flag then reports whether the remainder left by that stream equals the fixed residue of the code.

Top module: `crc32_stream`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done_o`, `crc_o` and `crc_ok_o` are all zero.
- R2: The code is the reflected CRC-32 with polynomial 0x04C11DB7 (0xEDB88320 in right-shifting form), initial remainder 0xFFFFFFFF and an inverted output. The nine ASCII bytes "123456789" give the codeword 0xCBF43926.
- R3: A start pulse reloads the remainder with 0xFFFFFFFF. A byte that is valid in the same cycle as start is applied to the reloaded value. A start pulse in the middle of a block discards everything accumulated before it.
- R4: In a cycle where `byte_valid_i` is low, the input byte has no effect. Idle cycles inserted between the bytes of a block leave the codeword unchanged.
- R5: `done_o` is high for exactly the one cycle that follows a cycle with an accepted byte that has `last_i` high. It is never high at any other time.
- R6: `crc_o` shows the bitwise inverse of the final remainder from the cycle `done_o` rises, and changes only when a later block completes. Valid bytes that arrive after the last byte and before the next start are ignored.
- R7: In check mode (`mode_check_i` high at start), `crc_ok_o` is high after done exactly when the final uninverted remainder equals 0xDEBB20E3. A stream followed by its correct codeword, least significant byte first, reports 1. Any corrupted byte reports 0. Outside check mode `crc_ok_o` is 0.
- R8: A block of a single byte, with start, valid and last all in one cycle, produces the correct codeword with done on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new block, reload remainder |
| mode_check_i | input | 1 | Sampled at start: 1 selects check mode |
| byte_valid_i | input | 1 | Input byte is valid this cycle |
| byte_i | input | 8 | Input byte |
| last_i | input | 1 | Qualifies the final byte of a block |
| done_o | output | 1 | One-cycle strobe after the last byte |
| crc_o | output | 32 | Codeword of the most recent block |
| crc_ok_o | output | 1 | Check-mode verdict of the most recent block |

## Verification
A wrong remainder, whether from a bad table entry, a missed reload or a byte accepted while valid was low, shows nothing until the block ends. It then appears at `crc_o` and `crc_ok_o` in the cycle after the last byte. The bench therefore runs a bit-serial reference model beside the design and compares all three outputs every cycle, so a divergence is caught in the first done cycle after it happens. Known-answer and check-mode blocks test the absolute values as well, so that an error shared by the model and the design cannot go unnoticed.

// File: rtl/crc32_pkg.sv
package crc32_pkg;

   localparam int unsigned CRC_W    = 32;
   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned LUT_N    = 1 << BYTE_W;
   localparam logic [CRC_W-1:0] POLY_REFL = 32'hEDB88320;
   localparam logic [CRC_W-1:0] SEED      = 32'hFFFF_FFFF;
   localparam logic [CRC_W-1:0] RESIDUE   = 32'hDEBB_20E3;

   // remainder of one byte value: 8 right shifts, fold polynomial on carry-out
   function automatic logic [CRC_W-1:0] lut_entry(input logic [BYTE_W-1:0] idx,
                                                  input logic [CRC_W-1:0]  poly);
      logic [CRC_W-1:0] r;
      r = {{(CRC_W-BYTE_W){1'b0}}, idx};
      for (int k = 0; k < BYTE_W; k++) begin
         if (r[0]) r = (r >> 1) ^ poly;
         else      r = r >> 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/crc32_lut.sv
module crc32_lut
   import crc32_pkg::*;
#(
   parameter logic [CRC_W-1:0] POLY    = POLY_REFL,
   parameter bit               USE_ROM = 1'b1
) (
   input  logic [BYTE_W-1:0] idx_i,
   output logic [CRC_W-1:0]  rem_o
);

   generate
      if (POLY == '0) begin : g_bad_poly
         $error("crc32_lut: polynomial must be non-zero");
      end

      if (USE_ROM) begin : g_rom
         logic [CRC_W-1:0] rom [LUT_N];
         for (genvar g = 0; g < LUT_N; g++) begin : g_ent
            assign rom[g] = lut_entry(BYTE_W'(g), POLY);
         end
         assign rem_o = rom[idx_i];
      end else begin : g_logic
         always_comb rem_o = lut_entry(idx_i, POLY);
      end
   endgenerate

endmodule

// File: rtl/crc32_core.sv
module crc32_core
   import crc32_pkg::*;
#(
   parameter logic [CRC_W-1:0] POLY    = POLY_REFL,
   parameter logic [CRC_W-1:0] INIT    = SEED,
   parameter bit               USE_ROM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              mode_i,
   input  logic              valid_i,
   input  logic [BYTE_W-1:0] data_i,
   input  logic              last_i,
   output logic              fin_o,
   output logic              fin_mode_o,
   output logic [CRC_W-1:0]  rem_next_o
);

   logic [CRC_W-1:0] state_q, base, lut_rem, nxt;
   logic             open_q, mode_q, accept, mode_eff;

   assign base     = start_i ? INIT : state_q;
   assign accept   = valid_i && (start_i || open_q);
   assign mode_eff = start_i ? mode_i : mode_q;

   crc32_lut #(.POLY(POLY), .USE_ROM(USE_ROM)) u_lut (
      .idx_i (base[BYTE_W-1:0] ^ data_i),
      .rem_o (lut_rem)
   );

   assign nxt = lut_rem ^ (base >> BYTE_W);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= INIT;
         open_q  <= 1'b0;
         mode_q  <= 1'b0;
      end else begin
         if (accept)       state_q <= nxt;
         else if (start_i) state_q <= INIT;
         if (start_i) mode_q <= mode_i;
         if (accept && last_i) open_q <= 1'b0;
         else if (start_i)     open_q <= 1'b1;
      end
   end

   assign fin_o      = accept && last_i;
   assign fin_mode_o = mode_eff;
   assign rem_next_o = nxt;

   // R4: with no byte and no start the remainder must not move
   assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_i && !start_i) |=> $stable(state_q));

   // R3: a bare start leaves the seed in the register
   assert_seed_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !valid_i) |=> (state_q == INIT));

endmodule

// File: rtl/crc32_stream.sv
module crc32_stream
   import crc32_pkg::*;
#(
   parameter int unsigned WIDTH   = CRC_W,
   parameter int unsigned BYTE    = BYTE_W,
   parameter bit          USE_ROM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              mode_check_i,
   input  logic              byte_valid_i,
   input  logic [BYTE-1:0]   byte_i,
   input  logic              last_i,
   output logic              done_o,
   output logic [WIDTH-1:0]  crc_o,
   output logic              crc_ok_o
);

   generate
      if (WIDTH != CRC_W || BYTE != BYTE_W) begin : g_bad_geom
         $error("crc32_stream: only 32-bit remainder over 8-bit bytes is built");
      end
   endgenerate

   logic             fin, fin_mode;
   logic [CRC_W-1:0] rem_next;

   crc32_core #(.POLY(POLY_REFL), .INIT(SEED), .USE_ROM(USE_ROM)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .mode_i     (mode_check_i),
      .valid_i    (byte_valid_i),
      .data_i     (byte_i),
      .last_i     (last_i),
      .fin_o      (fin),
      .fin_mode_o (fin_mode),
      .rem_next_o (rem_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_o   <= 1'b0;
         crc_o    <= '0;
         crc_ok_o <= 1'b0;
      end else begin
         done_o <= fin;
         if (fin) begin
            crc_o    <= ~rem_next;
            crc_ok_o <= fin_mode && (rem_next == RESIDUE);
         end
      end
   end

   // R5: done only follows a valid last byte
   assert_done_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(byte_valid_i && last_i));

   // R6: the codeword only moves on a done cycle
   assert_crc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(crc_o));

   // R7: a fresh good verdict appears together with done
   assert_ok_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crc_ok_o) |-> done_o);

   // R7: the verdict never changes between completions
   assert_ok_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(crc_ok_o));

endmodule

// File: tb/tb_crc32_stream.sv
module tb_crc32_stream;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, mode_check_i = 1'b0, byte_valid_i = 1'b0, last_i = 1'b0;
   logic [7:0]  byte_i = '0;
   logic        done_o, crc_ok_o;
   logic [31:0] crc_o;

   int total = 0, bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   crc32_stream dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_check_i(mode_check_i),
      .byte_valid_i(byte_valid_i), .byte_i(byte_i), .last_i(last_i),
      .done_o(done_o), .crc_o(crc_o), .crc_ok_o(crc_ok_o)
   );

   // bit-serial reference
   function automatic logic [31:0] ser_byte(input logic [31:0] s, input logic [7:0] d);
      logic [31:0] r = s;
      for (int k = 0; k < 8; k++) begin
         logic c = r[0] ^ d[k];
         r = r >> 1;
         if (c) r = r ^ 32'hEDB88320;
      end
      return r;
   endfunction

   function automatic logic [31:0] crc_of(input logic [7:0] q[$]);
      logic [31:0] s = 32'hFFFFFFFF;
      foreach (q[i]) s = ser_byte(s, q[i]);
      return ~s;
   endfunction

   logic [31:0] m_state = 32'hFFFFFFFF, exp_crc = '0, m_b;
   logic        m_open = 0, m_mode = 0, exp_done = 0, exp_ok = 0, m_acc, m_md;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state <= 32'hFFFFFFFF; m_open <= 0; m_mode <= 0;
         exp_done <= 0; exp_crc <= 0; exp_ok <= 0;
      end else begin
         m_acc = byte_valid_i && (start_i || m_open);
         m_md  = start_i ? mode_check_i : m_mode;
         m_b   = start_i ? 32'hFFFFFFFF : m_state;
         if (m_acc) m_b = ser_byte(m_b, byte_i);
         if (m_acc || start_i) m_state <= m_b;
         if (start_i) m_mode <= mode_check_i;
         if (m_acc && last_i) m_open <= 0; else if (start_i) m_open <= 1;
         exp_done <= m_acc && last_i;
         if (m_acc && last_i) begin
            exp_crc <= ~m_b;
            exp_ok  <= m_md && (m_b == 32'hDEBB20E3);
         end
      end
   end

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check("R5 done", {31'b0, done_o}, {31'b0, exp_done});
         check("R6 crc", crc_o, exp_crc);
         check("R7 ok", {31'b0, crc_ok_o}, {31'b0, exp_ok});
      end
   end

   task automatic drive(input logic st, input logic md, input logic v,
                        input logic [7:0] d, input logic l);
      @(posedge clk); #1;
      start_i = st; mode_check_i = md; byte_valid_i = v; byte_i = d; last_i = l;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(0, 0, 0, 8'hA5, 0);
   endtask

   // gap: idle cycles between bytes (valid low with junk data)
   task automatic run_block(input logic [7:0] q[$], input logic md, input int gap);
      for (int i = 0; i < q.size(); i++) begin
         drive(i == 0, md, 1, q[i], i == q.size() - 1);
         if (i != q.size() - 1) for (int g = 0; g < gap; g++) drive(0, 0, 0, ~q[i], 1);
      end
      drive(0, 0, 0, 8'h00, 0);
   endtask

   task automatic check_final(input string req, input logic [31:0] exp_c, input logic exp_k);
      @(negedge clk);
      check(req, {31'b0, done_o}, 32'd1);
      check(req, crc_o, exp_c);
      check(req, {31'b0, crc_ok_o}, {31'b0, exp_k});
   endtask

   initial begin
      logic [7:0] q[$];
      logic [7:0] r;
      logic [31:0] c;
      // R1: reset values
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 done", {31'b0, done_o}, 0);
      check("R1 crc", crc_o, 0);
      check("R1 ok", {31'b0, crc_ok_o}, 0);
      #1 rst_n = 1;
      @(negedge clk);
      check("R1 after", crc_o, 0);

      // R2: known answer
      q = '{8'h31,8'h32,8'h33,8'h34,8'h35,8'h36,8'h37,8'h38,8'h39};
      run_block(q, 0, 0);
      check_final("R2 known", 32'hCBF43926, 0);

      // R4: same block with idle gaps
      idle(2);
      run_block(q, 0, 3);
      check_final("R4 gaps", 32'hCBF43926, 0);

      // R6: stray bytes after last are ignored, codeword held
      for (int i = 0; i < 5; i++) drive(0, 0, 1, 8'(i * 17), i == 4);
      drive(0, 0, 0, 0, 0);
      @(negedge clk);
      check("R6 stray", crc_o, 32'hCBF43926);
      check("R6 stray done", {31'b0, done_o}, 0);

      // R8: single-byte block
      q = '{8'h00};
      run_block(q, 0, 0);
      check_final("R8 single", crc_of(q), 0);

      // R3: bare start, then bytes without start
      drive(1, 0, 0, 8'h55, 0);
      drive(0, 0, 1, 8'h31, 0);
      drive(0, 0, 1, 8'h32, 0);
      drive(0, 0, 1, 8'h33, 1);
      drive(0, 0, 0, 0, 0);
      q = '{8'h31,8'h32,8'h33};
      check_final("R3 bare start", crc_of(q), 0);

      // R3: restart mid-block discards earlier bytes
      drive(1, 0, 1, 8'hDE, 0);
      drive(0, 0, 1, 8'hAD, 0);
      q = '{8'h31,8'h32,8'h33,8'h34,8'h35,8'h36,8'h37,8'h38,8'h39};
      run_block(q, 0, 0);
      check_final("R3 restart", 32'hCBF43926, 0);

      // R7: check mode, good then corrupted
      q = '{8'h10,8'h20,8'h30,8'h40,8'h50};
      c = crc_of(q);
      q.push_back(c[7:0]); q.push_back(c[15:8]); q.push_back(c[23:16]); q.push_back(c[31:24]);
      run_block(q, 1, 1);
      check_final("R7 good", crc_of(q), 1);
      q[2] = q[2] ^ 8'h04;
      run_block(q, 1, 0);
      check_final("R7 corrupt", crc_of(q), 0);
      q[2] = q[2] ^ 8'h04;
      run_block(q, 0, 0);
      check_final("R7 off", crc_of(q), 0);

      // pseudo-random blocks, compared every cycle by the model
      r = 8'h5A;
      for (int b = 0; b < 40; b++) begin
         q = {};
         for (int i = 0; i < 1 + (b % 13); i++) begin
            r = {r[6:0], r[7] ^ r[5] ^ r[4] ^ r[3]};
            q.push_back(r ^ 8'(b));
         end
         run_block(q, b[0], b % 3);
         check_final("R2 random", crc_of(q), 0);
      end

      idle(3);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule